// File: doc/BRIEF.md
# Divisible Countdown Timer with Local Interrupt Entries

This block is a local countdown timer for a processor-side interrupt unit. Software picks a clock divider, writes a start value, and the timer then counts down once per divided tick. When the count runs out, the block records an expiry, and in one-shot mode it stops at zero. In periodic mode it reloads and keeps running. A six-entry table of local interrupt entries sits beside the timer. Entry 0 belongs to the timer: it carries the interrupt vector, a mask bit and the mode bit.

Expiries collect in a small saturating pending counter. The block raises a request while that counter is non-zero, the timer entry is unmasked and the unit is software-enabled. Each accepted acknowledge takes one expiry away. Clearing the software enable masks the whole entry table and drops every expiry still held. Registers are reached through a single-cycle write strobe and a read strobe whose data returns one clock later.

Top module: `local_timer`

## Requirements
- R1: After a synchronous active-low reset, control reads 0, divide config 0, start value 0, current count 0, every entry reads 0x0001_0000 (masked), and irq_req is low.
- R2: The divide select is {cfg[3], cfg[1], cfg[0]} (cfg bit 2 is not stored and reads 0). The count drops once every 2^((select+1) mod 8) clocks: select 7 divides by 1, select 0 by 2 and select 4 by 32.
- R3: A write to START (address 2) loads the current count with the written value the same edge. It restarts the divider, and the first decrement follows one full divided period later.
- R4: A start value of zero leaves the timer stopped: the current count reads 0 and no expiry occurs.
- R5: With entry 0 bit 17 clear (one-shot), the expiry happens on the tick that takes the count from 1 to 0. The count then stays 0 until START is written again.
- R6: With entry 0 bit 17 set (periodic), the tick that would reach zero reloads the count from the start value and records an expiry, every period.
- R7: Each expiry adds one to a pending counter that saturates at 2^PEND_W-1. An acknowledge while irq_req is high takes one away. When an acknowledge and an expiry fall in the same cycle, the counter is unchanged.
- R8: irq_req is high exactly while the pending counter is non-zero, entry 0 bit 16 (mask) is 0 and control bit 0 (enable) is 1. irq_vector always shows entry 0 bits 7:0.
- R9: Writing control bit 0 as 0 sets the mask bit of all six entries and clears the pending counter. This takes priority over an expiry in the same cycle.
- R10: An entry write (addresses 4 to 9) made while the unit is disabled is stored with its mask bit forced to 1.
- R11: A divide config write during a count does not reload the count. The new divisor governs the following ticks.
- R12: rdata is updated on the edge that samples rd_en and holds otherwise. Address map: 0 control, 1 divide config, 2 start value, 3 current count (read-only, writes ignored), 4 to 9 entries 0 to 5; other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_ack | input | 1 | Delivery accepted for the current request |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector of the timer entry |

## Verification
Two events can land in the same cycle and need checking together. One pair is an expiry with an acknowledge of a previous expiry. The other is an expiry with a software-disable write. The bench runs a periodic timer at divide-by-1 with the acknowledge held high, so that acknowledges and expiries overlap in most cycles. It then sweeps the disable write across every offset of a short period, so that one pass lands exactly on the expiry edge. A behavioural model, stepped every clock, predicts the pending count and judges the request and the read data cycle by cycle.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the local countdown timer: address map, entry
// field positions and the divider decode. Assumes a 32-bit register bus.
package lt_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int NUM_VEC  = 6;
    localparam int PRE_W    = 7;
    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] REG_DIV   = 4'h1;
    localparam logic [ADDR_W-1:0] REG_START = 4'h2;
    localparam logic [ADDR_W-1:0] REG_CURR  = 4'h3;
    localparam int                VEC_BASE  = 4;

    // Last prescaler value before a tick, from the 3-bit divide select
    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] sel);
        logic [2:0] sh;
        logic [7:0] pow;
        sh  = sel + 3'd1;
        pow = 8'd1 << sh;
        return PRE_W'(pow - 8'd1);
    endfunction
endpackage

// File: rtl/lt_prescaler.sv
`timescale 1ns/1ps
// Clock prescaler: emits one tick every 2^n clocks while the timer runs.
// Assumes restart is pulsed on every start-value write; a select change
// mid-count applies at the next comparison without clearing the count.
module lt_prescaler
    import lt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [2:0] div_sel,
    output logic       tick
);
    logic [PRE_W-1:0] presc;
    logic [PRE_W-1:0] limit;

    assign limit = div_limit(div_sel);
    assign tick  = run && (presc >= limit);

    // Count clocks between ticks; cleared by reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            presc <= '0;
        end else if (run) begin
            presc <= tick ? '0 : presc + 1'b1;
        end
    end
endmodule

// File: rtl/lt_counter.sv
`timescale 1ns/1ps
// Down-counter with one-shot or periodic reload. A load wins over a tick
// in the same cycle. Expiry is the tick that takes the count from 1 to 0.
module lt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && running && !load && (cur == ONE);

    // Load, decrement, and reload or stop at the end of a period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cur     <= load_val;
            running <= |load_val;
        end else if (tick && running) begin
            if (cur == ONE) begin
                cur     <= periodic ? reload_val : '0;
                running <= periodic;
            end else begin
                cur <= cur - ONE;
            end
        end
    end
endmodule

// File: rtl/lt_pending.sv
`timescale 1ns/1ps
// Saturating count of undelivered expiries. Clear has priority; a
// simultaneous increment and decrement leave the count as it is.
module lt_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              clr,
    output logic [PEND_W-1:0] count
);
    localparam logic [PEND_W-1:0] MAX = {PEND_W{1'b1}};

    // Track expiries minus accepted deliveries
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && !dec) begin
            if (count != MAX) count <= count + 1'b1;
        end else if (dec && !inc) begin
            if (count != '0) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/local_timer.sv
`timescale 1ns/1ps
// Local countdown timer top: register file, six local interrupt entries,
// prescaler, counter and pending tracking. Single-cycle writes; reads
// return data one clock after rd_en. Assumes CNT_W <= 32.
module local_timer
    import lt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [7:0]        irq_vector
);
    logic                 sw_en;
    logic [2:0]           div_sel;
    logic [CNT_W-1:0]     init_q;
    logic [NUM_VEC-1:0]   vmask;
    logic [7:0]           vvec [NUM_VEC];
    logic                 periodic;
    logic [CNT_W-1:0]     cur_cnt;
    logic                 running;
    logic                 expire;
    logic                 tick;
    logic [PEND_W-1:0]    pend_cnt;
    logic                 wr_ctrl;
    logic                 wr_start;
    logic                 disable_wr;
    logic                 ack_ok;
    logic [DATA_W-1:0]    rd_mux;

    assign wr_ctrl    = wr_en && (addr == REG_CTRL);
    assign wr_start   = wr_en && (addr == REG_START);
    assign disable_wr = wr_ctrl && !wdata[0];

    // Control, divide select and start value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en   <= 1'b0;
            div_sel <= 3'd0;
            init_q  <= '0;
        end else if (wr_en) begin
            if (addr == REG_CTRL)  sw_en   <= wdata[0];
            if (addr == REG_DIV)   div_sel <= {wdata[3], wdata[1:0]};
            if (addr == REG_START) init_q  <= wdata[CNT_W-1:0];
        end
    end

    generate
        for (genvar i = 0; i < NUM_VEC; i++) begin : g_entry
            logic wr_this;
            assign wr_this = wr_en && (addr == ADDR_W'(VEC_BASE + i));
            // One local entry: mask forced on disable or while disabled
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vmask[i] <= 1'b1;
                    vvec[i]  <= 8'd0;
                end else if (disable_wr) begin
                    vmask[i] <= 1'b1;
                end else if (wr_this) begin
                    vmask[i] <= wdata[MASK_BIT] | !sw_en;
                    vvec[i]  <= wdata[7:0];
                end
            end
        end
    endgenerate

    // Mode bit, held only by the timer entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periodic <= 1'b0;
        end else if (wr_en && (addr == ADDR_W'(VEC_BASE))) begin
            periodic <= wdata[MODE_BIT];
        end
    end

    lt_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_start),
        .run     (running),
        .div_sel (div_sel),
        .tick    (tick)
    );

    lt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_start),
        .load_val   (wdata[CNT_W-1:0]),
        .reload_val (init_q),
        .tick       (tick),
        .periodic   (periodic),
        .cur        (cur_cnt),
        .running    (running),
        .expire     (expire)
    );

    assign irq_req    = sw_en && !vmask[0] && (pend_cnt != '0);
    assign irq_vector = vvec[0];
    assign ack_ok     = irq_ack && irq_req;

    lt_pending #(.PEND_W(PEND_W)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (expire),
        .dec   (ack_ok),
        .clr   (disable_wr),
        .count (pend_cnt)
    );

    // Read multiplexer over the address map
    always_comb begin
        rd_mux = '0;
        case (addr)
            REG_CTRL:  rd_mux[0] = sw_en;
            REG_DIV:   rd_mux[3:0] = {div_sel[2], 1'b0, div_sel[1:0]};
            REG_START: rd_mux = DATA_W'(init_q);
            REG_CURR:  rd_mux = DATA_W'(cur_cnt);
            default: begin
                for (int i = 0; i < NUM_VEC; i++) begin
                    if (addr == ADDR_W'(VEC_BASE + i)) begin
                        rd_mux[7:0]      = vvec[i];
                        rd_mux[MASK_BIT] = vmask[i];
                        if (i == 0) rd_mux[MODE_BIT] = periodic;
                    end
                end
            end
        endcase
    end

    // Registered read data, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/lt_checker.sv
`timescale 1ns/1ps
// Property checker for local_timer, attached with bind below.
module lt_checker #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        addr,
    input logic [31:0]       wdata,
    input logic              irq_req,
    input logic              irq_ack,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  init_q,
    input logic              expire,
    input logic              periodic,
    input logic [PEND_W-1:0] pend_cnt,
    input logic [5:0]        vmask
);
    logic was_rst;
    logic dis_w;
    logic start_w;

    assign dis_w   = wr_en && (addr == 4'h0) && !wdata[0];
    assign start_w = wr_en && (addr == 4'h2);

    // Remember that the previous edge applied reset
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: state right after a reset edge
    always_ff @(posedge clk) begin
        if (was_rst == 1'b1) begin
            assert_reset_state_R1: assert (cur_cnt == '0 && pend_cnt == '0 && vmask == 6'h3f && !irq_req)
                else $error("reset state wrong");
        end
    end

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> cur_cnt == CNT_W'($past(wdata)));

    assert_zero_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cnt == '0 && !start_w) |=> cur_cnt == '0);

    assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> cur_cnt == $past(init_q));

    assert_ack_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !expire && !dis_w) |=> pend_cnt == $past(pend_cnt) - 1'b1);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dis_w |=> (vmask == 6'h3f && pend_cnt == '0 && !irq_req));
endmodule

bind local_timer lt_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .cur_cnt  (cur_cnt),
    .init_q   (init_q),
    .expire   (expire),
    .periodic (periodic),
    .pend_cnt (pend_cnt),
    .vmask    (vmask)
);

// File: tb/local_timer_bench.sv
`timescale 1ns/1ps
// Bench for local_timer: behavioural model stepped every clock, plus
// directed checks on exact values and cycle counts.
module local_timer_bench;
    localparam int PMAX = 15;
    localparam int WDOG = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    string phase = "R1";

    // model state
    bit          m_en;
    bit [3:0]    m_div;
    logic [31:0] m_init, m_cur, m_rdata;
    int          m_presc, m_pend;
    bit          m_run, m_per;
    bit          m_mask [6];
    logic [7:0]  m_vec [6];

    local_timer u_local_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_vector(irq_vector)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run is a failure that still reaches the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            errors++;
            $display("FAIL WDOG cycles %0d expected below %0d", cycles, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int divisor(bit [3:0] c);
        int s;
        s = (c[3] ? 4 : 0) + (c[1] ? 2 : 0) + (c[0] ? 1 : 0);
        return 1 << ((s + 1) % 8);
    endfunction

    function automatic logic [31:0] model_read(logic [3:0] a);
        logic [31:0] v;
        v = 32'h0;
        if (a == 0) v[0] = m_en;
        else if (a == 1) v[3:0] = {m_div[3], 1'b0, m_div[1:0]};
        else if (a == 2) v = m_init;
        else if (a == 3) v = m_cur;
        else if (a >= 4 && a <= 9) begin
            v[7:0] = m_vec[a-4];
            v[16]  = m_mask[a-4];
            if (a == 4) v[17] = m_per;
        end
        return v;
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    // One clock: advance the model on the current inputs, then compare
    task automatic step();
        bit req_old, tick, load, expire, ack_eff, clr;
        if (!rst_n) begin
            m_en = 0; m_div = 0; m_init = 0; m_cur = 0; m_rdata = 0;
            m_presc = 0; m_pend = 0; m_run = 0; m_per = 0;
            for (int i = 0; i < 6; i++) begin m_mask[i] = 1; m_vec[i] = 0; end
        end else begin
            req_old = m_en && !m_mask[0] && m_pend != 0;
            load    = wr_en && addr == 2;
            tick    = m_run && (m_presc >= divisor(m_div) - 1);
            expire  = tick && !load && m_cur == 1;
            ack_eff = irq_ack && req_old;
            clr     = wr_en && addr == 0 && !wdata[0];
            if (rd_en) m_rdata = model_read(addr);
            if (clr) m_pend = 0;
            else if (expire && !ack_eff) m_pend = (m_pend < PMAX) ? m_pend + 1 : PMAX;
            else if (ack_eff && !expire) m_pend = m_pend - 1;
            if (load) m_presc = 0;
            else if (m_run) m_presc = tick ? 0 : m_presc + 1;
            if (load) begin
                m_cur = wdata; m_run = (wdata != 0);
            end else if (tick) begin
                if (m_cur == 1) begin
                    m_cur = m_per ? m_init : 0; m_run = m_per;
                end else m_cur = m_cur - 1;
            end
            if (wr_en) begin
                if (addr == 2) m_init = wdata;
                if (addr == 1) m_div = {wdata[3], 1'b0, wdata[1:0]};
                if (addr >= 4 && addr <= 9) begin
                    m_mask[addr-4] = wdata[16] | !m_en;
                    m_vec[addr-4]  = wdata[7:0];
                    if (addr == 4) m_per = wdata[17];
                end
                if (addr == 0) begin
                    m_en = wdata[0];
                    if (!wdata[0]) for (int i = 0; i < 6; i++) m_mask[i] = 1;
                end
            end
        end
        @(posedge clk);
        #1;
        check(phase, "irq_req", {31'b0, irq_req}, {31'b0, m_en && !m_mask[0] && m_pend != 0});
        check(phase, "irq_vector", {24'b0, irq_vector}, {24'b0, m_vec[0]});
        check(phase, "rdata", rdata, m_rdata);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        step();
        wr_en = 0; wdata = 0;
    endtask

    task automatic rd(logic [3:0] a);
        rd_en = 1; addr = a;
        step();
        rd_en = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset values
        phase = "R1";
        for (int a = 0; a < 10; a++) rd(4'(a));
        rd(4); check("R1", "entry0 reset", rdata, 32'h0001_0000);
        rd(9); check("R1", "entry5 reset", rdata, 32'h0001_0000);
        rd(3); check("R1", "current count reset", rdata, 32'h0);
        // R10 entry write while disabled
        phase = "R10";
        wr(4, 32'h0000_0033); rd(4); check("R10", "forced mask", rdata, 32'h0001_0033);
        wr(0, 1);
        wr(4, 32'h0000_0041);
        // R2 divide by 1, start 5: expiry on fifth edge after the load
        phase = "R2";
        wr(1, 32'hB); wr(2, 5);
        idle(4); check("R2", "irq before expiry div1", {31'b0, irq_req}, 0);
        idle(1); check("R2", "irq at expiry div1", {31'b0, irq_req}, 1);
        check("R8", "vector", {24'b0, irq_vector}, 32'h41);
        irq_ack = 1; step(); irq_ack = 0;
        // R5 one-shot stays at zero
        phase = "R5";
        idle(10); rd(3); check("R5", "oneshot held at zero", rdata, 0);
        // R2 divide by 2 and by 32
        phase = "R2";
        wr(1, 32'h0); wr(2, 3);
        idle(5); check("R2", "irq before expiry div2", {31'b0, irq_req}, 0);
        idle(1); check("R2", "irq at expiry div2", {31'b0, irq_req}, 1);
        irq_ack = 1; step(); irq_ack = 0;
        wr(1, 32'h8); wr(2, 2);
        idle(63); check("R2", "irq before expiry div32", {31'b0, irq_req}, 0);
        idle(1); check("R2", "irq at expiry div32", {31'b0, irq_req}, 1);
        irq_ack = 1; step(); irq_ack = 0;
        wr(1, 32'h4); rd(1); check("R2", "cfg bit2 not stored", rdata, 0);
        // R4 zero start value
        phase = "R4";
        wr(2, 0); idle(20); rd(3); check("R4", "zero start stopped", rdata, 0);
        check("R4", "no request", {31'b0, irq_req}, 0);
        // R3 restart mid-count
        phase = "R3";
        wr(1, 32'hB); wr(2, 100); idle(10); wr(2, 50); idle(3);
        rd(3); check("R3", "count after restart", rdata, 47);
        // R11 divider change mid-count
        phase = "R11";
        wr(1, 32'h0); idle(9); rd(3); wr(1, 32'hB); idle(5); rd(3);
        // R12 read-only current count and unmapped address
        phase = "R12";
        wr(3, 32'h1234); rd(3); rd(4'hF); check("R12", "unmapped read", rdata, 0);
        // R6/R7 periodic, saturation, then draining with overlapping acks
        phase = "R6";
        wr(2, 0); wr(4, 32'h0002_0055); wr(2, 4);
        idle(100);
        phase = "R7";
        irq_ack = 1; idle(40); irq_ack = 0;
        idle(10);
        // R8 masking the timer entry hides the request
        phase = "R8";
        wr(4, 32'h0003_0055); idle(20);
        check("R8", "masked entry no request", {31'b0, irq_req}, 0);
        wr(4, 32'h0002_0055);
        check("R8", "unmasked request", {31'b0, irq_req}, 1);
        // R9 disable masks all and drops pending, swept against expiry
        phase = "R9";
        wr(0, 0);
        check("R9", "request after disable", {31'b0, irq_req}, 0);
        for (int a = 4; a < 10; a++) begin
            rd(4'(a)); check("R9", "mask after disable", {31'b0, rdata[16]}, 1);
        end
        for (int k = 0; k < 8; k++) begin
            wr(0, 1); wr(4, 32'h0002_0055); wr(2, 3);
            idle(k); wr(0, 0); idle(2);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule